// File: doc/BRIEF.md
# Shared Out-of-Order Issue Queue

This block holds decoded instructions of one class (integer, address generation or floating point; each class gets its own instance) between dispatch and execution in an out-of-order core. Dispatch hands over at most one instruction per cycle, in program order. Each instruction carries two physical source tags, a ready flag for each tag, a destination tag and an opcode. An instruction waits in the queue until both of its sources are ready. It then leaves through one of two identical issue ports. Because every port serves every entry, an instruction is never bound to one particular functional unit.

Each cycle, up to two result tags are broadcast. Every stored source whose tag matches a broadcast becomes ready, and the entry can issue from the following cycle on. Among the entries that are ready, the oldest go first. An entry that is still waiting keeps its slot and its contents while younger ready entries pass it. When all sixteen slots are in use, the queue raises a stall towards dispatch. A flush input empties the queue in one cycle.

Top module: `iq_issue_queue`

## Requirements
- R1: The queue holds up to 16 entries. `disp_stall` is 1 exactly when 16 entries are stored. A dispatch offered while `disp_stall` is 1 is dropped and never issues.
- R2: Issue port p (p = 0 or 1) asserts `iss_valid[p]` only in a cycle where `fu_free[p]` is 1. It issues only an entry whose two ready flags are both set.
- R3: In each cycle, the oldest ready entry goes to the lowest-numbered port that is free, and the next-oldest ready entry goes to the next free port. At most two entries issue per cycle, and an entry issues only once.
- R4: A broadcast with `wake_valid[w]`=1 and tag `wake_tag[w*6 +: 6]` sets the ready flag of every stored source with that tag. The woken entry cannot issue in the broadcast cycle. It can issue in the next cycle.
- R5: If an incoming instruction has a source tag equal to a broadcast in the same cycle, that source is stored as ready.
- R6: A dispatched instruction never issues in the cycle in which it is presented. If its sources are ready, it can issue in the next cycle at the earliest.
- R7: An entry that is not ready stays in the queue with unchanged contents, while younger ready entries issue ahead of it.
- R8: In a cycle with `flush`=1, nothing issues and any dispatch is dropped. From the next cycle on, the queue is empty.
- R9: Issue port p presents the destination tag and the opcode of the entry it issues, on `iss_dst[p*6 +: 6]` and `iss_op[p*8 +: 8]`.
- R10: After reset, the queue is empty: `disp_stall`=0 and `iss_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Drop every stored entry |
| disp_valid | input | 1 | Dispatch offers an instruction |
| disp_src0_tag | input | 6 | First source physical tag |
| disp_src0_rdy | input | 1 | First source already available |
| disp_src1_tag | input | 6 | Second source physical tag |
| disp_src1_rdy | input | 1 | Second source already available |
| disp_dst_tag | input | 6 | Destination physical tag |
| disp_op | input | 8 | Opcode carried to the unit |
| disp_stall | output | 1 | Queue full, dispatch must hold |
| wake_valid | input | 2 | One valid bit per result broadcast |
| wake_tag | input | 12 | Broadcast tags, 6 bits each |
| fu_free | input | 2 | Functional unit behind port p can accept |
| iss_valid | output | 2 | Port p issues this cycle |
| iss_dst | output | 12 | Destination tag for each port |
| iss_op | output | 16 | Opcode for each port |

## Verification
The bench aims at the timing edges of wakeup. It checks a broadcast that lands in the same cycle as the dispatch of its consumer: a design that ignores the incoming instruction would leave that entry waiting forever. It also checks a broadcast to a stored entry: a design that forwards it straight to selection would issue a cycle early. Oldest-first order is checked with only port 1 free and an older blocked entry in front. A wrong design would send the blocked entry, send the younger one to the wrong port, or shift contents over the waiting entry. Filling all sixteen slots, offering one more instruction and then waking everything checks that exactly sixteen instructions issue. A random phase compares every cycle against a list-based model, with frequent flushes that must silence the ports at once.

// File: rtl/iq_pkg.sv
package iq_pkg;

  parameter int unsigned TAG_W = 6;
  parameter int unsigned OP_W  = 8;

  typedef logic [TAG_W-1:0] tag_t;
  typedef logic [OP_W-1:0]  op_t;

  typedef struct packed {
    tag_t a_tag;
    logic a_rdy;
    tag_t b_tag;
    logic b_rdy;
    tag_t dst;
    op_t  op;
  } iq_ent_t;

  function automatic logic ent_can_go(input iq_ent_t e);
    return e.a_rdy & e.b_rdy;
  endfunction

  function automatic logic tag_match(input tag_t t, input logic v, input tag_t w);
    return v && (t == w);
  endfunction

endpackage

// File: rtl/iq_wake.sv
module iq_wake
  import iq_pkg::*;
#(
  parameter int unsigned WAKE_N = 2
) (
  input  iq_ent_t                   ent_i,
  input  logic [WAKE_N-1:0]         bc_valid,
  input  logic [WAKE_N*TAG_W-1:0]   bc_tag,
  output iq_ent_t                   ent_o
);

  always_comb begin
    ent_o = ent_i;
    for (int w = 0; w < WAKE_N; w++) begin
      if (tag_match(ent_i.a_tag, bc_valid[w], bc_tag[w*TAG_W +: TAG_W])) ent_o.a_rdy = 1'b1;
      if (tag_match(ent_i.b_tag, bc_valid[w], bc_tag[w*TAG_W +: TAG_W])) ent_o.b_rdy = 1'b1;
    end
  end

endmodule

// File: rtl/iq_select.sv
module iq_select #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PORTS = 2,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]       req,
  input  logic [PORTS-1:0]       port_en,
  output logic [PORTS-1:0]       gnt_vld,
  output logic [PORTS*IDX_W-1:0] gnt_idx,
  output logic [DEPTH-1:0]       taken
);

  logic [DEPTH-1:0] remain;
  logic             found;

  // Slot 0 is the oldest; each enabled port takes the lowest remaining request.
  always_comb begin
    remain  = req;
    taken   = '0;
    gnt_vld = '0;
    gnt_idx = '0;
    found   = 1'b0;
    for (int p = 0; p < PORTS; p++) begin
      found = 1'b0;
      if (port_en[p]) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (!found && remain[i]) begin
            found                        = 1'b1;
            gnt_vld[p]                   = 1'b1;
            gnt_idx[p*IDX_W +: IDX_W]    = IDX_W'(i);
            remain[i]                    = 1'b0;
            taken[i]                     = 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/iq_pack.sv
module iq_pack
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  iq_ent_t          cur_i [DEPTH],
  input  logic [DEPTH-1:0] keep_i,
  input  iq_ent_t          new_i,
  input  logic             new_acc,
  output iq_ent_t          nxt_o [DEPTH],
  output logic [DEPTH-1:0] nxt_vld
);

  logic [CNT_W-1:0] wr;

  // Survivors slide toward slot 0 keeping their order; the newcomer lands behind them.
  always_comb begin
    wr      = '0;
    nxt_vld = '0;
    for (int i = 0; i < DEPTH; i++) nxt_o[i] = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (keep_i[j]) begin
        nxt_o[wr[IDX_W-1:0]]   = cur_i[j];
        nxt_vld[wr[IDX_W-1:0]] = 1'b1;
        wr                     = wr + CNT_W'(1);
      end
    end
    if (new_acc && (wr < CNT_W'(DEPTH))) begin
      nxt_o[wr[IDX_W-1:0]]   = new_i;
      nxt_vld[wr[IDX_W-1:0]] = 1'b1;
    end
  end

endmodule

// File: rtl/iq_issue_queue.sv
module iq_issue_queue
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned ISSUE_N = 2,
  parameter int unsigned WAKE_N  = 2,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     disp_valid,
  input  logic [TAG_W-1:0]         disp_src0_tag,
  input  logic                     disp_src0_rdy,
  input  logic [TAG_W-1:0]         disp_src1_tag,
  input  logic                     disp_src1_rdy,
  input  logic [TAG_W-1:0]         disp_dst_tag,
  input  logic [OP_W-1:0]          disp_op,
  output logic                     disp_stall,
  input  logic [WAKE_N-1:0]        wake_valid,
  input  logic [WAKE_N*TAG_W-1:0]  wake_tag,
  input  logic [ISSUE_N-1:0]       fu_free,
  output logic [ISSUE_N-1:0]       iss_valid,
  output logic [ISSUE_N*TAG_W-1:0] iss_dst,
  output logic [ISSUE_N*OP_W-1:0]  iss_op
);

  function automatic logic [CNT_W-1:0] occupancy(input logic [DEPTH-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < DEPTH; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  iq_ent_t              ent_q   [DEPTH];
  logic [DEPTH-1:0]     vld_q;
  iq_ent_t              ent_wk  [DEPTH];
  iq_ent_t              ent_nxt [DEPTH];
  logic [DEPTH-1:0]     vld_nxt;
  iq_ent_t              disp_ent;
  iq_ent_t              disp_wk;
  logic [DEPTH-1:0]     req_vec;
  logic [DEPTH-1:0]     taken;
  logic [DEPTH-1:0]     keep;
  logic [ISSUE_N-1:0]   port_en;
  logic [ISSUE_N-1:0]   gnt_vld;
  logic [ISSUE_N*IDX_W-1:0] gnt_idx;
  logic [CNT_W-1:0]     occ;
  logic                 accept;

  assign disp_ent = '{a_tag: disp_src0_tag, a_rdy: disp_src0_rdy,
                      b_tag: disp_src1_tag, b_rdy: disp_src1_rdy,
                      dst: disp_dst_tag, op: disp_op};

  // Wakeup for each stored slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    iq_wake #(.WAKE_N(WAKE_N)) u_wake (
      .ent_i    (ent_q[g]),
      .bc_valid (wake_valid),
      .bc_tag   (wake_tag),
      .ent_o    (ent_wk[g])
    );
    assign req_vec[g] = vld_q[g] & ent_can_go(ent_q[g]);
  end

  // Same-cycle capture for the incoming instruction
  iq_wake #(.WAKE_N(WAKE_N)) u_wake_in (
    .ent_i    (disp_ent),
    .bc_valid (wake_valid),
    .bc_tag   (wake_tag),
    .ent_o    (disp_wk)
  );

  assign port_en = fu_free & {ISSUE_N{~flush}};

  iq_select #(.DEPTH(DEPTH), .PORTS(ISSUE_N)) u_sel (
    .req     (req_vec),
    .port_en (port_en),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx),
    .taken   (taken)
  );

  assign occ        = occupancy(vld_q);
  assign disp_stall = (occ == CNT_W'(DEPTH));
  assign accept     = disp_valid & ~flush & ~disp_stall;
  assign keep       = vld_q & ~taken;

  iq_pack #(.DEPTH(DEPTH)) u_pack (
    .cur_i   (ent_wk),
    .keep_i  (keep),
    .new_i   (disp_wk),
    .new_acc (accept),
    .nxt_o   (ent_nxt),
    .nxt_vld (vld_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_nxt;
      ent_q <= ent_nxt;
    end
  end

  for (genvar p = 0; p < ISSUE_N; p++) begin : g_port
    assign iss_valid[p]               = gnt_vld[p];
    assign iss_dst[p*TAG_W +: TAG_W]  = ent_q[gnt_idx[p*IDX_W +: IDX_W]].dst;
    assign iss_op[p*OP_W +: OP_W]     = ent_q[gnt_idx[p*IDX_W +: IDX_W]].op;
  end

endmodule

// File: rtl/iq_issue_queue_chk.sv
module iq_issue_queue_chk #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned ISSUE_N = 2,
  parameter int unsigned CNT_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               disp_valid,
  input logic               disp_stall,
  input logic [ISSUE_N-1:0] fu_free,
  input logic [ISSUE_N-1:0] iss_valid,
  input logic               accept,
  input logic [DEPTH-1:0]   taken,
  input logic [CNT_W-1:0]   occ
);

  // R1: occupancy never passes capacity
  a_r1_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  // R1: occupancy moves by arrivals minus departures
  a_r1_occ_step: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> occ == CNT_W'($past(occ) + CNT_W'($past(accept)) - CNT_W'($countones($past(taken)))));

  // R1: full queue with nothing leaving stays full
  a_r1_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_stall && disp_valid && !flush && taken == '0) |=> disp_stall);

  // R2: no port issues without a free unit behind it
  a_r2_port_free: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid & ~fu_free) == '0);

  // R3: issue count matches selected slot count
  a_r3_one_slot_per_port: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_valid) == $countones(taken));

  // R8: flush silences ports and empties the queue
  a_r8_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> iss_valid == '0);
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> occ == '0);

endmodule

bind iq_issue_queue iq_issue_queue_chk #(.DEPTH(DEPTH), .ISSUE_N(ISSUE_N), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .disp_valid (disp_valid),
  .disp_stall (disp_stall),
  .fu_free    (fu_free),
  .iss_valid  (iss_valid),
  .accept     (accept),
  .taken      (taken),
  .occ        (occ)
);

// File: tb/iq_issue_queue_tb.sv
module iq_issue_queue_tb_top;

  localparam int DEPTH = 16;
  localparam int TW = 6;
  localparam int OW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          flush;
  logic          disp_valid;
  logic [TW-1:0] disp_src0_tag, disp_src1_tag, disp_dst_tag;
  logic          disp_src0_rdy, disp_src1_rdy;
  logic [OW-1:0] disp_op;
  logic          disp_stall;
  logic [1:0]    wake_valid;
  logic [2*TW-1:0] wake_tag;
  logic [1:0]    fu_free;
  logic [1:0]    iss_valid;
  logic [2*TW-1:0] iss_dst;
  logic [2*OW-1:0] iss_op;

  always #4 clk = ~clk;

  iq_issue_queue dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .disp_valid(disp_valid),
    .disp_src0_tag(disp_src0_tag), .disp_src0_rdy(disp_src0_rdy),
    .disp_src1_tag(disp_src1_tag), .disp_src1_rdy(disp_src1_rdy),
    .disp_dst_tag(disp_dst_tag), .disp_op(disp_op), .disp_stall(disp_stall),
    .wake_valid(wake_valid), .wake_tag(wake_tag), .fu_free(fu_free),
    .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_op(iss_op)
  );

  typedef struct { int s0; bit r0; int s1; bit r1; int dst; int op; } ment_t;
  ment_t mq[$];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit hit(int tag);
    for (int w = 0; w < 2; w++)
      if (wake_valid[w] && int'(wake_tag[w*TW +: TW]) == tag) return 1'b1;
    return 1'b0;
  endfunction

  task automatic idle();
    flush = 0; disp_valid = 0; disp_src0_tag = 0; disp_src0_rdy = 0;
    disp_src1_tag = 0; disp_src1_rdy = 0; disp_dst_tag = 0; disp_op = 0;
    wake_valid = 0; wake_tag = 0; fu_free = 2'b11;
  endtask

  task automatic put(int s0, bit r0, int s1, bit r1, int dst, int op);
    disp_valid = 1; disp_src0_tag = TW'(s0); disp_src0_rdy = r0;
    disp_src1_tag = TW'(s1); disp_src1_rdy = r1; disp_dst_tag = TW'(dst); disp_op = OW'(op);
  endtask

  // Compare against the model for this cycle, advance the model, go to next negedge.
  task automatic tick();
    int ev[2];
    int ei[2];
    bit tk[DEPTH];
    ment_t ne;
    bit acc;
    for (int i = 0; i < DEPTH; i++) tk[i] = 0;
    for (int p = 0; p < 2; p++) begin
      ev[p] = 0; ei[p] = 0;
      if (!flush && fu_free[p]) begin
        for (int i = 0; i < mq.size(); i++) begin
          if (!tk[i] && mq[i].r0 && mq[i].r1) begin
            ev[p] = 1; ei[p] = i; tk[i] = 1;
            break;
          end
        end
      end
    end
    chk(disp_stall == (mq.size() == DEPTH), "R1 stall", int'(disp_stall), int'(mq.size() == DEPTH));
    for (int p = 0; p < 2; p++) begin
      chk(int'(iss_valid[p]) == ev[p], "R3 issue valid", int'(iss_valid[p]), ev[p]);
      if (iss_valid[p] && ev[p] == 1) begin
        chk(int'(iss_dst[p*TW +: TW]) == mq[ei[p]].dst, "R9 dst", int'(iss_dst[p*TW +: TW]), mq[ei[p]].dst);
        chk(int'(iss_op[p*OW +: OW]) == mq[ei[p]].op, "R9 op", int'(iss_op[p*OW +: OW]), mq[ei[p]].op);
      end
    end
    if (flush) begin
      mq.delete();
    end else begin
      acc = disp_valid && (mq.size() < DEPTH);
      ne.s0 = int'(disp_src0_tag); ne.s1 = int'(disp_src1_tag);
      ne.r0 = disp_src0_rdy || hit(ne.s0);
      ne.r1 = disp_src1_rdy || hit(ne.s1);
      ne.dst = int'(disp_dst_tag); ne.op = int'(disp_op);
      for (int i = 0; i < mq.size(); i++) begin
        if (hit(mq[i].s0)) mq[i].r0 = 1;
        if (hit(mq[i].s1)) mq[i].r1 = 1;
      end
      for (int i = DEPTH - 1; i >= 0; i--) if (tk[i]) mq.delete(i);
      if (acc) mq.push_back(ne);
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int sum;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(disp_stall == 0, "R10 stall", int'(disp_stall), 0);
    chk(iss_valid == 0, "R10 issue", int'(iss_valid), 0);
    rst_n = 1;
    @(negedge clk);

    // R6: ready arrival waits one cycle
    idle(); put(1, 1, 2, 1, 1, 17); #1;
    chk(iss_valid == 2'b00, "R6 same cycle", int'(iss_valid), 0);
    tick();
    idle(); #1;
    chk(iss_valid == 2'b01, "R6 next cycle", int'(iss_valid), 1);
    chk(int'(iss_dst[TW-1:0]) == 1, "R9 dst", int'(iss_dst[TW-1:0]), 1);
    tick();

    // R4: stored source woken by broadcast
    idle(); put(5, 0, 0, 1, 2, 18); tick();
    idle(); wake_valid = 2'b01; wake_tag[TW-1:0] = 5; #1;
    chk(iss_valid == 2'b00, "R4 wake cycle", int'(iss_valid), 0);
    tick();
    idle(); #1;
    chk(iss_valid == 2'b01, "R4 after wake", int'(iss_valid), 1);
    chk(int'(iss_dst[TW-1:0]) == 2, "R4 dst", int'(iss_dst[TW-1:0]), 2);
    tick();

    // R5: broadcast caught during dispatch
    idle(); put(0, 1, 7, 0, 3, 19); wake_valid = 2'b10; wake_tag[2*TW-1:TW] = 7; tick();
    idle(); #1;
    chk(iss_valid == 2'b01, "R5 captured", int'(iss_valid), 1);
    chk(int'(iss_dst[TW-1:0]) == 3, "R5 dst", int'(iss_dst[TW-1:0]), 3);
    tick();

    // R3 / R7 / R2: oldest-first past a waiting entry
    idle(); put(9, 0, 0, 1, 21, 31); tick();
    idle(); fu_free = 2'b00; put(0, 1, 0, 1, 22, 32); tick();
    idle(); fu_free = 2'b00; put(0, 1, 0, 1, 23, 33); #1;
    chk(iss_valid == 2'b00, "R2 no free unit", int'(iss_valid), 0);
    tick();
    idle(); fu_free = 2'b10; #1;
    chk(iss_valid == 2'b10, "R3 port1 only", int'(iss_valid), 2);
    chk(int'(iss_dst[2*TW-1:TW]) == 22, "R7 younger passes", int'(iss_dst[2*TW-1:TW]), 22);
    tick();
    idle(); fu_free = 2'b01; wake_valid = 2'b01; wake_tag[TW-1:0] = 9; #1;
    chk(int'(iss_dst[TW-1:0]) == 23, "R4 woken not yet", int'(iss_dst[TW-1:0]), 23);
    tick();
    idle(); #1;
    chk(iss_valid == 2'b01, "R7 waiting issues", int'(iss_valid), 1);
    chk(int'(iss_dst[TW-1:0]) == 21, "R7 contents kept", int'(iss_dst[TW-1:0]), 21);
    tick();

    // R1: fill, drop an extra, drain
    for (int i = 0; i < DEPTH; i++) begin
      idle(); put(40, 0, 0, 1, 30 + i, i); tick();
    end
    idle(); put(0, 1, 0, 1, 60, 99); #1;
    chk(disp_stall == 1, "R1 full", int'(disp_stall), 1);
    tick();
    idle(); wake_valid = 2'b01; wake_tag[TW-1:0] = 40; tick();
    sum = 0;
    for (int c = 0; c < 10; c++) begin
      idle(); #1;
      for (int p = 0; p < 2; p++) begin
        if (iss_valid[p]) begin
          sum++;
          chk(int'(iss_dst[p*TW +: TW]) != 60, "R1 dropped entry", int'(iss_dst[p*TW +: TW]), -1);
        end
      end
      tick();
    end
    chk(sum == DEPTH, "R1 drain count", sum, DEPTH);

    // R8: flush
    for (int i = 0; i < 3; i++) begin
      idle(); fu_free = 2'b00; put(0, 1, 0, 1, 11 + i, 40 + i); tick();
    end
    idle(); flush = 1; put(0, 1, 0, 1, 14, 44); #1;
    chk(iss_valid == 2'b00, "R8 flush cycle", int'(iss_valid), 0);
    tick();
    idle(); #1;
    chk(iss_valid == 2'b00, "R8 emptied", int'(iss_valid), 0);
    chk(disp_stall == 0, "R8 stall", int'(disp_stall), 0);
    tick();

    // Random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      idle();
      flush = ($urandom_range(63) == 0);
      if ($urandom_range(9) < 7)
        put($urandom_range(15), $urandom_range(1) == 1, $urandom_range(15), $urandom_range(1) == 1,
            $urandom_range(63), $urandom_range(255));
      wake_valid[0] = ($urandom_range(9) < 4);
      wake_valid[1] = ($urandom_range(9) < 4);
      wake_tag[TW-1:0] = TW'($urandom_range(15));
      wake_tag[2*TW-1:TW] = TW'($urandom_range(15));
      fu_free = 2'($urandom_range(3));
      #1;
      tick();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule